// File: doc/BRIEF.md
# Two-Level Maskable Interrupt Controller

This block turns two event lines from a host-access unit into a single interrupt pin. Each event line has its own sticky status bit. A status bit is set on the rising edge of its event, whatever its enable says. Software clears a status bit by writing 1 to it. A per-source enable decides which pending bits count. The counted bits are ORed into a module flag. A per-module enable then decides whether that flag reaches the pin. A configuration field sets the pin polarity, and the pin is driven from a register.

Software reaches every register through a flat read/write port: an address, write data, a write strobe, a read strobe and combinational read data. Only the host-access module is wired in. The module enable and module flag registers keep bit 0 for it, so more modules can be added at higher bits later.

Top module: `irq_ctrl`

## Requirements
- R1: After reset, every register reads 0 and `irq_o` is 0. Reset leaves the polarity at active-high, so 0 is the inactive level.
- R2: A rising edge on `evt_i[0]` sets status bit 3 at address 0x102. A rising edge on `evt_i[1]` sets status bit 4. This happens even when the source is disabled. An event input that stays high does not set the bit again after a clear.
- R3: Writing 1 to status bit 3 or 4 clears that bit. Writing 0 leaves it unchanged. A set bit stays set until it is cleared this way.
- R4: An event edge and a write-1 clear on the same bit in the same cycle leave the bit set.
- R5: The source enable register at 0x104 holds enables in bits 3 (timeout) and 4 (done). Both bits are read/write, and all other bits read 0.
- R6: The module enable register at 0x21A holds a read/write enable in bit 0. All other bits read 0.
- R7: Bit 0 of the flag register at 0x210 is read-only. It reads 1 while any status bit is both set and enabled at 0x104, regardless of the module enable. Writes to 0x210 are ignored.
- R8: One cycle after the internal request changes, the pin reaches its active level. The request is the module flag ANDed with the module enable. The pin stays active until every enabled pending bit is cleared or an enable is removed.
- R9: Bits [15:14] of the configuration register at 0x218 set the pin polarity: 00 is active-high, 01 is active-low, and 10 and 11 are active-high. This field is read/write, and all other bits of the register read 0.
- R10: Unmapped addresses read 0. `rdata_o` is 0 whenever `rd_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 12 | Register address |
| wdata_i | input | 16 | Write data |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| rdata_o | output | 16 | Read data, valid while rd_i is high |
| evt_i | input | 2 | Event lines: bit 0 read-timeout, bit 1 read-done |
| irq_o | output | 1 | Interrupt pin, registered |

## Verification
The bench fires an event in the same cycle as a write-1 clear of the same bit. A design that gave the clear priority would drop that event. It holds an event line high across a clear, which catches a design that latches on level instead of on edge. It clears one of two pending sources and checks that the pin stays active. It then disables the module with a bit still pending, so a design that mixed up the two enable levels would move the pin or the flag wrongly. Each of the four polarity codes is also driven, both with and without a pending source. This catches a design that inverts on the wrong code.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;

  typedef enum logic [1:0] {
    POL_HIGH   = 2'b00,
    POL_LOW    = 2'b01,
    POL_HIGH_2 = 2'b10,
    POL_HIGH_3 = 2'b11
  } irq_pol_e;

  function automatic logic pol_is_low(input logic [1:0] code);
    return irq_pol_e'(code) == POL_LOW;
  endfunction

endpackage

// File: rtl/irq_src_cell.sv
module irq_src_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic evt_i,
  input  logic clr_i,
  input  logic en_we_i,
  input  logic en_d_i,
  output logic status_o,
  output logic en_o,
  output logic pend_o
);

  logic evt_q;
  logic rise;

  assign rise = evt_i & ~evt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      evt_q    <= 1'b0;
      status_o <= 1'b0;
      en_o     <= 1'b0;
    end else begin
      evt_q <= evt_i;
      // set has priority over clear
      if (rise)       status_o <= 1'b1;
      else if (clr_i) status_o <= 1'b0;
      if (en_we_i)    en_o     <= en_d_i;
    end
  end

  assign pend_o = status_o & en_o;

endmodule

// File: rtl/irq_out_stage.sv
module irq_out_stage
  import irq_ctrl_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_i,
  input  logic [1:0] pol_i,
  output logic       irq_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= 1'b0;
    else         irq_o <= req_i ^ pol_is_low(pol_i);
  end

endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl #(
  parameter int              ADDR_W      = 12,
  parameter int              DATA_W      = 16,
  parameter int              NUM_SRC     = 2,
  parameter int              SRC_LSB     = 3,
  parameter int              POL_LSB     = 14,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 12'h102,
  parameter logic [ADDR_W-1:0] SRC_EN_ADDR = 12'h104,
  parameter logic [ADDR_W-1:0] FLAG_ADDR   = 12'h210,
  parameter logic [ADDR_W-1:0] MOD_EN_ADDR = 12'h21A,
  parameter logic [ADDR_W-1:0] CFG_ADDR    = 12'h218
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              wr_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [NUM_SRC-1:0] evt_i,
  output logic              irq_o
);

  localparam int POL_W = 2;

  logic [NUM_SRC-1:0] status_q;
  logic [NUM_SRC-1:0] src_en_q;
  logic [NUM_SRC-1:0] pend;
  logic               mod_en_q;
  logic [POL_W-1:0]   pol_q;
  logic               flag;
  logic               wr_status, wr_src_en, wr_mod_en, wr_cfg;

  assign wr_status = wr_i && (addr_i == STATUS_ADDR);
  assign wr_src_en = wr_i && (addr_i == SRC_EN_ADDR);
  assign wr_mod_en = wr_i && (addr_i == MOD_EN_ADDR);
  assign wr_cfg    = wr_i && (addr_i == CFG_ADDR);

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    irq_src_cell u_cell (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .evt_i    (evt_i[g]),
      .clr_i    (wr_status & wdata_i[SRC_LSB+g]),
      .en_we_i  (wr_src_en),
      .en_d_i   (wdata_i[SRC_LSB+g]),
      .status_o (status_q[g]),
      .en_o     (src_en_q[g]),
      .pend_o   (pend[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mod_en_q <= 1'b0;
      pol_q    <= '0;
    end else begin
      if (wr_mod_en) mod_en_q <= wdata_i[0];
      if (wr_cfg)    pol_q    <= wdata_i[POL_LSB +: POL_W];
    end
  end

  assign flag = |pend;

  irq_out_stage u_out (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (flag & mod_en_q),
    .pol_i  (pol_q),
    .irq_o  (irq_o)
  );

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      if (addr_i == STATUS_ADDR)      rdata_o[SRC_LSB +: NUM_SRC] = status_q;
      else if (addr_i == SRC_EN_ADDR) rdata_o[SRC_LSB +: NUM_SRC] = src_en_q;
      else if (addr_i == FLAG_ADDR)   rdata_o[0] = flag;
      else if (addr_i == MOD_EN_ADDR) rdata_o[0] = mod_en_q;
      else if (addr_i == CFG_ADDR)    rdata_o[POL_LSB +: POL_W] = pol_q;
    end
  end

endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk #(
  parameter int                ADDR_W      = 12,
  parameter int                DATA_W      = 16,
  parameter int                NUM_SRC     = 2,
  parameter int                SRC_LSB     = 3,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 12'h102
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [ADDR_W-1:0]  addr_i,
  input logic [DATA_W-1:0]  wdata_i,
  input logic               wr_i,
  input logic [NUM_SRC-1:0] evt_i,
  input logic [NUM_SRC-1:0] status_i,
  input logic [NUM_SRC-1:0] src_en_i,
  input logic               mod_en_i,
  input logic [1:0]         pol_i,
  input logic               irq_i
);

  logic [NUM_SRC-1:0] evt_seen;
  logic [NUM_SRC-1:0] rise, clr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) evt_seen <= '0;
    else         evt_seen <= evt_i;
  end

  assign rise = evt_i & ~evt_seen;
  assign clr  = (wr_i && addr_i == STATUS_ADDR) ? wdata_i[SRC_LSB +: NUM_SRC] : '0;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_bit
    AST_EVT_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rise[g] |=> status_i[g]);  // R2
    AST_W1C_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr[g] && !rise[g]) |=> !status_i[g]);  // R3
    AST_STATUS_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (status_i[g] && !clr[g]) |=> status_i[g]);  // R3
    AST_EVT_BEATS_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr[g] && rise[g]) |=> status_i[g]);  // R4
  end

  AST_PIN_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> irq_i == ($past((|(status_i & src_en_i)) & mod_en_i) ^ $past(pol_i == 2'b01)));  // R8

endmodule

bind irq_ctrl irq_ctrl_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_SRC(NUM_SRC),
  .SRC_LSB(SRC_LSB), .STATUS_ADDR(STATUS_ADDR)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .addr_i   (addr_i),
  .wdata_i  (wdata_i),
  .wr_i     (wr_i),
  .evt_i    (evt_i),
  .status_i (status_q),
  .src_en_i (src_en_q),
  .mod_en_i (mod_en_q),
  .pol_i    (pol_q),
  .irq_i    (irq_o)
);

// File: tb/irq_ctrl_tb.sv
module irq_ctrl_tb;

  localparam logic [11:0] A_STAT = 12'h102;
  localparam logic [11:0] A_SEN  = 12'h104;
  localparam logic [11:0] A_FLAG = 12'h210;
  localparam logic [11:0] A_MEN  = 12'h21A;
  localparam logic [11:0] A_CFG  = 12'h218;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [11:0] addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic        wr_i = 1'b0;
  logic        rd_i = 1'b0;
  logic [15:0] rdata_o;
  logic [1:0]  evt_i = '0;
  logic        irq_o;

  int vectors = 0;
  int errors  = 0;

  always #10 clk_i = ~clk_i;

  irq_ctrl u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wdata_i(wdata_i),
    .wr_i(wr_i), .rd_i(rd_i), .rdata_o(rdata_o), .evt_i(evt_i), .irq_o(irq_o)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk_i);
  endtask

  task automatic wr(input logic [11:0] a, input logic [15:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; wr_i = 1'b1;
    @(negedge clk_i);
    wr_i = 1'b0; wdata_i = '0;
  endtask

  task automatic rd_chk(input string req, input logic [11:0] a, input logic [15:0] exp);
    @(negedge clk_i);
    addr_i = a; rd_i = 1'b1;
    #2;
    check(req, rdata_o, exp);
    rd_i = 1'b0;
  endtask

  task automatic pulse(input int idx);
    @(negedge clk_i);
    evt_i[idx] = 1'b1;
    @(negedge clk_i);
    evt_i[idx] = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 irq", {15'd0, irq_o}, 16'h0);
    rd_chk("R1 status", A_STAT, 16'h0);
    rd_chk("R1 src_en", A_SEN, 16'h0);
    rd_chk("R1 flag", A_FLAG, 16'h0);
    rd_chk("R1 mod_en", A_MEN, 16'h0);
    rd_chk("R1 cfg", A_CFG, 16'h0);
  endtask

  task automatic t_regs();
    wr(A_SEN, 16'hFFFF);
    rd_chk("R5 src_en mask", A_SEN, 16'h0018);
    wr(A_MEN, 16'hFFFF);
    rd_chk("R6 mod_en mask", A_MEN, 16'h0001);
    wr(A_CFG, 16'hFFFF);
    rd_chk("R9 cfg mask", A_CFG, 16'hC000);
    wr(A_FLAG, 16'hFFFF);
    rd_chk("R7 flag read-only", A_FLAG, 16'h0000);
    wr(A_SEN, 16'h0);
    wr(A_MEN, 16'h0);
    wr(A_CFG, 16'h0);
    rd_chk("R5 src_en cleared", A_SEN, 16'h0);
  endtask

  task automatic t_events();
    pulse(0);
    rd_chk("R2 timeout sets bit3", A_STAT, 16'h0008);
    step();
    check("R8 disabled source no pin", {15'd0, irq_o}, 16'h0);
    rd_chk("R7 disabled source no flag", A_FLAG, 16'h0);
    pulse(1);
    rd_chk("R2 done sets bit4", A_STAT, 16'h0018);
    wr(A_STAT, 16'h0000);
    rd_chk("R3 write 0 no effect", A_STAT, 16'h0018);
    wr(A_STAT, 16'h0008);
    rd_chk("R3 clear bit3 only", A_STAT, 16'h0010);
    wr(A_STAT, 16'h0010);
    rd_chk("R3 clear bit4", A_STAT, 16'h0000);
    @(negedge clk_i) evt_i[0] = 1'b1;
    step();
    wr(A_STAT, 16'h0008);
    step();
    rd_chk("R2 held level no reset", A_STAT, 16'h0000);
    evt_i[0] = 1'b0;
    step();
  endtask

  task automatic t_collision();
    @(negedge clk_i);
    evt_i[1] = 1'b1; addr_i = A_STAT; wdata_i = 16'h0010; wr_i = 1'b1;
    @(negedge clk_i);
    wr_i = 1'b0; wdata_i = '0; evt_i[1] = 1'b0;
    rd_chk("R4 event beats clear", A_STAT, 16'h0010);
    wr(A_STAT, 16'h0018);
    rd_chk("R4 cleanup", A_STAT, 16'h0000);
  endtask

  task automatic t_pin();
    wr(A_SEN, 16'h0018);
    wr(A_MEN, 16'h0001);
    step();
    check("R8 idle pin", {15'd0, irq_o}, 16'h0);
    pulse(0);
    step();
    check("R8 pin active", {15'd0, irq_o}, 16'h1);
    rd_chk("R7 flag set", A_FLAG, 16'h0001);
    pulse(1);
    wr(A_STAT, 16'h0008);
    step();
    check("R8 pin held by other source", {15'd0, irq_o}, 16'h1);
    wr(A_MEN, 16'h0000);
    step();
    check("R8 module disable drops pin", {15'd0, irq_o}, 16'h0);
    rd_chk("R7 flag ignores module enable", A_FLAG, 16'h0001);
    wr(A_MEN, 16'h0001);
    step();
    check("R8 module reenable", {15'd0, irq_o}, 16'h1);
    wr(A_STAT, 16'h0010);
    step();
    check("R8 pin released", {15'd0, irq_o}, 16'h0);
    rd_chk("R7 flag cleared", A_FLAG, 16'h0000);
  endtask

  task automatic t_polarity();
    logic [1:0] codes [4] = '{2'b00, 2'b01, 2'b10, 2'b11};
    for (int i = 0; i < 4; i++) begin
      logic low;
      low = (codes[i] == 2'b01);
      wr(A_CFG, {codes[i], 14'h3FFF});
      step();
      check($sformatf("R9 idle code %0d", i), {15'd0, irq_o}, {15'd0, low});
      pulse(0);
      step();
      check($sformatf("R9 active code %0d", i), {15'd0, irq_o}, {15'd0, ~low});
      wr(A_STAT, 16'h0008);
      step();
    end
    wr(A_CFG, 16'h0);
  endtask

  task automatic t_unmapped();
    rd_chk("R10 unmapped 0x000", 12'h000, 16'h0);
    rd_chk("R10 unmapped 0x106", 12'h106, 16'h0);
    wr(A_MEN, 16'h0001);
    @(negedge clk_i);
    addr_i = A_MEN; rd_i = 1'b0;
    #2;
    check("R10 no strobe no data", rdata_o, 16'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    step();
    t_reset();
    t_regs();
    t_events();
    t_collision();
    t_pin();
    t_polarity();
    t_unmapped();
    step();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    vectors++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule